// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit virtual address into a 52-bit physical address. It walks a radix page table with four levels, starting from a root table page number given on an input. At each level it reads one 64-bit entry through a memory port. It allows only one outstanding read at a time and holds each request until the memory side accepts it. Read data returns on a separate response strobe, in some later cycle.

While it walks, the block tracks the permissions in force across all the entries it has read. It stops with a fault cause as soon as an entry is absent or a permission is violated. When an entry's accessed flag needs setting, or the last entry's dirty flag does, it writes the modified entry back to the address it was read from, before it moves on. Writes are posted: a write is complete once the memory port accepts it. A requester hands over one translation at a time and receives a single response, which is held until it is taken.

Top module: `pt_walker`

## Requirements
- R1: The level-k read (k = 1..4) goes to address {table_ppn, idx_k, 3'b000}. The 9-bit indices are vaddr[47:39], [38:30], [29:21] and [20:12] for levels 1 to 4. table_ppn is root_ppn_i for level 1; for each later level it is bits 51:12 of the previous entry. Reads go out in level order. A memory request is held stable until mem_req_ready_i.
- R2: An entry with bit 0 clear ends the walk with rsp_fault_o=1, rsp_cause_o=2'b01 and rsp_paddr_o=0. No later level is read and nothing is written.
- R3: A write request (req_write_i=1) needs bit 1 set in every entry read so far. The first level where this fails ends the walk with cause 2'b10, and that entry is not written.
- R4: A user request needs bit 2 set in every entry read so far. A fetch request needs bit 63 clear in every entry read so far. A violation of either gives cause 2'b11. It takes priority over cause 2'b10 at the same level, and the entry is not written.
- R5: A present entry that passes the checks but has bit 5 clear is written back to its own address with bit 5 set and its other bits unchanged. The write happens before the next level is read.
- R6: On a write request that passes, the level-4 entry also gets bit 6 set. Bit 6 of level 1 to 3 entries is never changed, and read requests never set it.
- R7: An entry whose written-back value would equal its read value is not written.
- R8: A walk that passes all four levels responds with rsp_fault_o=0, rsp_cause_o=2'b00 and rsp_paddr_o = {level-4 entry bits 51:12, vaddr[11:0]}.
- R9: rsp_valid_o, with its fault, cause and address, stays stable until rsp_ready_i.
- R10: req_ready_o is high out of reset. It goes low from the acceptance of a request until the cycle after the response handshake, so only one walk runs at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle and able to take a request |
| req_vaddr_i | input | 48 | Virtual address to translate |
| req_write_i | input | 1 | Access is a store |
| req_user_i | input | 1 | Access is made in user mode |
| req_fetch_i | input | 1 | Access is an instruction fetch |
| root_ppn_i | input | 40 | Page number of the level-1 table |
| mem_req_valid_o | output | 1 | Memory request valid |
| mem_req_ready_i | input | 1 | Memory accepts the request |
| mem_req_write_o | output | 1 | Request is an entry write-back |
| mem_req_addr_o | output | 52 | Entry byte address |
| mem_req_wdata_o | output | 64 | Write-back data |
| mem_rsp_valid_i | input | 1 | Read data valid |
| mem_rsp_rdata_i | input | 64 | Read data |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_fault_o | output | 1 | Walk ended in a fault |
| rsp_cause_o | output | 2 | Fault cause: 00 none, 01 absent, 10 read-only, 11 privilege or fetch |
| rsp_paddr_o | output | 52 | Physical address, zero on a fault |

## Verification
The bench injects each fault kind at each of the four levels:
- A design that checked only the current entry, and not the accumulated ones, would let a deep access pass below a restrictive upper entry.
- One that ranked the causes wrongly would report 2'b10 where a user store hits a supervisor read-only entry.

It also checks which entries get written:
- A walker that wrote every entry would show extra write counts on tables whose accessed and dirty flags were already set.
- One that set the dirty flag at the wrong level, or on loads, would leave a mismatching entry in the bench's memory.

Random tables with random reserved bits, random memory back-pressure and a held response catch:
- lost bits in written-back entries;
- a misplaced index or base field;
- a response that changes while it waits.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_ABSENT = 2'b01,
    CAUSE_RO     = 2'b10,
    CAUSE_PRIV   = 2'b11
  } cause_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_WAIT,
    ST_WR,
    ST_RESP
  } state_e;

  // entry flag positions
  localparam int unsigned BIT_P  = 0;
  localparam int unsigned BIT_RW = 1;
  localparam int unsigned BIT_US = 2;
  localparam int unsigned BIT_A  = 5;
  localparam int unsigned BIT_D  = 6;
  localparam int unsigned BIT_NX = 63;

  typedef struct packed {
    logic rw;
    logic us;
    logic nx;
  } perm_t;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 52,
  localparam int unsigned VPN_W   = LEVELS * IDX_W,
  localparam int unsigned PPN_W   = PA_W - OFF_W,
  localparam int unsigned LVL_W   = $clog2(LEVELS),
  localparam int unsigned ENT_LSB = OFF_W - IDX_W
) (
  input  logic [PPN_W-1:0] tbase_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PA_W-1:0]  addr_o
);

  logic [IDX_W-1:0] idx [LEVELS];

  // level 0 takes the most significant slice
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idx[g] = vpn_i[(LEVELS-1-g)*IDX_W +: IDX_W];
  end

  assign addr_o = {tbase_i, idx[lvl_i], {ENT_LSB{1'b0}}};

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte_i,
  input  logic             last_i,
  input  perm_t            acc_i,
  input  logic             wr_i,
  input  logic             user_i,
  input  logic             fetch_i,
  output perm_t            acc_o,
  output logic             fault_o,
  output cause_e           cause_o,
  output logic             wb_o,
  output logic [PTE_W-1:0] pte_o
);

  always_comb begin
    acc_o.rw = acc_i.rw & pte_i[BIT_RW];
    acc_o.us = acc_i.us & pte_i[BIT_US];
    acc_o.nx = acc_i.nx | pte_i[BIT_NX];

    pte_o        = pte_i;
    pte_o[BIT_A] = 1'b1;
    if (last_i && wr_i) pte_o[BIT_D] = 1'b1;

    cause_o = CAUSE_NONE;
    if (!pte_i[BIT_P]) begin
      cause_o = CAUSE_ABSENT;
    end else if ((user_i && !acc_o.us) || (fetch_i && acc_o.nx)) begin
      cause_o = CAUSE_PRIV;
    end else if (wr_i && !acc_o.rw) begin
      cause_o = CAUSE_RO;
    end
    fault_o = (cause_o != CAUSE_NONE);
    wb_o    = !fault_o && (pte_o != pte_i);
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned LEVELS = 4,
  parameter int unsigned IDX_W  = 9,
  parameter int unsigned OFF_W  = 12,
  parameter int unsigned PA_W   = 52,
  parameter int unsigned PTE_W  = 64,
  localparam int unsigned VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int unsigned PPN_W = PA_W - OFF_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic             req_write_i,
  input  logic             req_user_i,
  input  logic             req_fetch_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic             mem_req_write_o,
  output logic [PA_W-1:0]  mem_req_addr_o,
  output logic [PTE_W-1:0] mem_req_wdata_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_rdata_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic             rsp_fault_o,
  output logic [1:0]       rsp_cause_o,
  output logic [PA_W-1:0]  rsp_paddr_o
);

  localparam int unsigned LVL_W = $clog2(LEVELS);

  state_e           state_q;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic             wr_q, user_q, fetch_q;
  logic [PPN_W-1:0] tbase_q;
  perm_t            acc_q;
  logic [PTE_W-1:0] pte_q;
  logic [PA_W-1:0]  ent_addr_q;
  logic             fault_q;
  cause_e           cause_q;
  logic [PA_W-1:0]  paddr_q;

  logic [PA_W-1:0]  rd_addr;
  logic             last;
  perm_t            chk_acc;
  logic             chk_fault;
  cause_e           chk_cause;
  logic             chk_wb;
  logic [PTE_W-1:0] chk_pte;

  assign last = (lvl_q == LVL_W'(LEVELS - 1));

  pt_addr_gen #(
    .LEVELS (LEVELS),
    .IDX_W  (IDX_W),
    .OFF_W  (OFF_W),
    .PA_W   (PA_W)
  ) i_addr_gen (
    .tbase_i (tbase_q),
    .vpn_i   (va_q[VA_W-1:OFF_W]),
    .lvl_i   (lvl_q),
    .addr_o  (rd_addr)
  );

  pt_entry_check #(
    .PTE_W (PTE_W)
  ) i_entry_check (
    .pte_i   (mem_rsp_rdata_i),
    .last_i  (last),
    .acc_i   (acc_q),
    .wr_i    (wr_q),
    .user_i  (user_q),
    .fetch_i (fetch_q),
    .acc_o   (chk_acc),
    .fault_o (chk_fault),
    .cause_o (chk_cause),
    .wb_o    (chk_wb),
    .pte_o   (chk_pte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      lvl_q      <= '0;
      va_q       <= '0;
      wr_q       <= 1'b0;
      user_q     <= 1'b0;
      fetch_q    <= 1'b0;
      tbase_q    <= '0;
      acc_q      <= '{rw: 1'b1, us: 1'b1, nx: 1'b0};
      pte_q      <= '0;
      ent_addr_q <= '0;
      fault_q    <= 1'b0;
      cause_q    <= CAUSE_NONE;
      paddr_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            va_q    <= req_vaddr_i;
            wr_q    <= req_write_i;
            user_q  <= req_user_i;
            fetch_q <= req_fetch_i;
            tbase_q <= root_ppn_i;
            lvl_q   <= '0;
            acc_q   <= '{rw: 1'b1, us: 1'b1, nx: 1'b0};
            fault_q <= 1'b0;
            cause_q <= CAUSE_NONE;
            paddr_q <= '0;
            state_q <= ST_RD;
          end
        end
        ST_RD: begin
          if (mem_req_ready_i) begin
            ent_addr_q <= rd_addr;
            state_q    <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (mem_rsp_valid_i) begin
            acc_q   <= chk_acc;
            pte_q   <= chk_pte;
            tbase_q <= mem_rsp_rdata_i[PA_W-1:OFF_W];
            if (chk_fault) begin
              fault_q <= 1'b1;
              cause_q <= chk_cause;
              state_q <= ST_RESP;
            end else begin
              if (last) paddr_q <= {mem_rsp_rdata_i[PA_W-1:OFF_W], va_q[OFF_W-1:0]};
              if (chk_wb) begin
                state_q <= ST_WR;
              end else if (last) begin
                state_q <= ST_RESP;
              end else begin
                lvl_q   <= lvl_q + 1'b1;
                state_q <= ST_RD;
              end
            end
          end
        end
        ST_WR: begin
          if (mem_req_ready_i) begin
            if (last) begin
              state_q <= ST_RESP;
            end else begin
              lvl_q   <= lvl_q + 1'b1;
              state_q <= ST_RD;
            end
          end
        end
        ST_RESP: begin
          if (rsp_ready_i) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_RD) || (state_q == ST_WR);
  assign mem_req_write_o = (state_q == ST_WR);
  assign mem_req_addr_o  = (state_q == ST_WR) ? ent_addr_q : rd_addr;
  assign mem_req_wdata_o = pte_q;
  assign rsp_valid_o     = (state_q == ST_RESP);
  assign rsp_fault_o     = fault_q;
  assign rsp_cause_o     = cause_q;
  assign rsp_paddr_o     = paddr_q;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int unsigned OFF_W = 12,
  parameter int unsigned PA_W  = 52
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [OFF_W-1:0] off_i,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic             mem_req_write_o,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             wdata_a_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic             rsp_fault_o,
  input logic [1:0]       rsp_cause_o,
  input logic [PA_W-1:0]  rsp_paddr_o
);

  logic [OFF_W-1:0] off_q;
  logic [PA_W-1:0]  rd_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_q     <= '0;
      rd_addr_q <= '0;
    end else begin
      if (req_valid_i && req_ready_o) off_q <= off_i;
      if (mem_req_valid_o && mem_req_ready_i && !mem_req_write_o) rd_addr_q <= mem_req_addr_o;
    end
  end

  AST_ACCEPT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |-> !rsp_valid_o && !mem_req_valid_o); // R10
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o); // R10
  AST_MREQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && !mem_req_ready_i |=> mem_req_valid_o && $stable(mem_req_addr_o) && $stable(mem_req_write_o)); // R1
  AST_MREQ_ALIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> mem_req_addr_o[2:0] == 3'b000); // R1
  AST_WB_SAME_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_write_o |-> mem_req_addr_o == rd_addr_q); // R5
  AST_WB_ACCESSED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o && mem_req_write_o |-> wdata_a_i); // R5
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o) && $stable(rsp_cause_o)); // R9
  AST_OK_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_fault_o |-> rsp_paddr_o[OFF_W-1:0] == off_q); // R8
  AST_FAULT_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_fault_o == (rsp_cause_o != 2'b00)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_fault_o |-> rsp_paddr_o == '0); // R2
  AST_RSP_NO_MREQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !mem_req_valid_o); // R10

endmodule

bind pt_walker pt_walker_chk #(
  .OFF_W (OFF_W),
  .PA_W  (PA_W)
) i_pt_walker_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .off_i           (req_vaddr_i[OFF_W-1:0]),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_write_o (mem_req_write_o),
  .mem_req_addr_o  (mem_req_addr_o),
  .wdata_a_i       (mem_req_wdata_o[pt_walker_pkg::BIT_A]),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_fault_o     (rsp_fault_o),
  .rsp_cause_o     (rsp_cause_o),
  .rsp_paddr_o     (rsp_paddr_o)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [47:0] req_vaddr = '0;
  logic        req_write = 1'b0, req_user = 1'b0, req_fetch = 1'b0;
  logic [39:0] root_ppn = '0;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_rdata = '0;
  logic        rsp_valid, rsp_fault;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_cause;
  logic [51:0] rsp_paddr;

  always #2 clk = ~clk;

  pt_walker i_pt_walker (
    .clk_i           (clk),
    .rst_ni          (rst_n),
    .req_valid_i     (req_valid),
    .req_ready_o     (req_ready),
    .req_vaddr_i     (req_vaddr),
    .req_write_i     (req_write),
    .req_user_i      (req_user),
    .req_fetch_i     (req_fetch),
    .root_ppn_i      (root_ppn),
    .mem_req_valid_o (mem_req_valid),
    .mem_req_ready_i (mem_req_ready),
    .mem_req_write_o (mem_req_write),
    .mem_req_addr_o  (mem_req_addr),
    .mem_req_wdata_o (mem_req_wdata),
    .mem_rsp_valid_i (mem_rsp_valid),
    .mem_rsp_rdata_i (mem_rsp_rdata),
    .rsp_valid_o     (rsp_valid),
    .rsp_ready_i     (rsp_ready),
    .rsp_fault_o     (rsp_fault),
    .rsp_cause_o     (rsp_cause),
    .rsp_paddr_o     (rsp_paddr)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model: sparse store, random back-pressure and read latency
  logic [63:0] mem [logic [51:0]];
  logic [51:0] rd_log [$];
  int          wr_cnt = 0;
  logic        pend = 1'b0;
  logic [51:0] pend_addr = '0;
  int          pend_dly = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      pend = 1'b0;
    end else begin
      mem_rsp_valid <= 1'b0;
      if (pend) begin
        if (pend_dly == 0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
          pend = 1'b0;
        end else begin
          pend_dly--;
        end
      end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_write) begin
          mem[mem_req_addr] = mem_req_wdata;
          wr_cnt++;
        end else begin
          rd_log.push_back(mem_req_addr);
          pend      = 1'b1;
          pend_addr = mem_req_addr;
          pend_dly  = int'($urandom % 3);
        end
      end
      mem_req_ready <= ($urandom % 4) != 0;
    end
  end

  // walk scenario and expected results
  logic [63:0] ent [4];
  logic [63:0] exp_ent [4];
  logic [51:0] ent_addr [4];
  logic [39:0] tb [5];
  logic [47:0] va;
  logic        w, u, f;
  logic [51:0] exp_rd [4];
  int          exp_nrd, exp_nwr;
  logic [1:0]  exp_cause;
  logic [51:0] exp_pa;

  task automatic model();
    logic rw = 1'b1, us = 1'b1, nx = 1'b0;
    logic [39:0] b = tb[0];
    exp_cause = 2'b00; exp_nrd = 0; exp_nwr = 0; exp_pa = '0;
    for (int k = 0; k < 4; k++) exp_ent[k] = ent[k];
    for (int k = 0; k < 4; k++) begin
      exp_rd[k] = {b, va[47-9*k -: 9], 3'b000};
      exp_nrd++;
      if (!ent[k][0]) begin exp_cause = 2'b01; break; end
      rw &= ent[k][1]; us &= ent[k][2]; nx |= ent[k][63];
      if ((u && !us) || (f && nx)) begin exp_cause = 2'b11; break; end
      if (w && !rw) begin exp_cause = 2'b10; break; end
      exp_ent[k] = ent[k] | 64'h20 | ((k == 3 && w) ? 64'h40 : 64'h0);
      if (exp_ent[k] != ent[k]) exp_nwr++;
      b = ent[k][51:12];
    end
    if (exp_cause == 2'b00) exp_pa = {b, va[11:0]};
  endtask

  // inj < 0: random tables; else kind selects the injected case
  task automatic run(input int inj, input int kind, input int hold);
    logic [63:0] r, e;
    string       tag;
    int          n;
    logic        bad;
    logic [51:0] pa0;
    logic [1:0]  c0;
    r = {$urandom(), $urandom()};
    va = r[47:0];
    for (int k = 0; k < 5; k++) begin
      r = {$urandom(), $urandom()};
      tb[k] = {r[37:0], 2'(k)};
    end
    for (int k = 0; k < 4; k++) begin
      r = {$urandom(), $urandom()};
      e = r;
      e[51:12] = tb[k+1];
      if (inj < 0) begin
        e[0]  = ($urandom % 16) != 0;
        e[1]  = ($urandom % 4) != 0;
        e[2]  = ($urandom % 4) != 0;
        e[63] = ($urandom % 10) == 0;
      end else begin
        e[0] = 1'b1; e[1] = 1'b1; e[2] = 1'b1; e[63] = 1'b0;
        if (kind == 5) begin e[5] = 1'b1; e[6] = 1'b1; end
        if (kind == 6) e[5] = 1'b0;
        if (k == inj) begin
          case (kind)
            0: e[0] = 1'b0;
            1: e[1] = 1'b0;
            2: e[2] = 1'b0;
            3: e[63] = 1'b1;
            4: begin e[1] = 1'b0; e[2] = 1'b0; end
            default: ;
          endcase
        end
      end
      ent[k] = e;
      ent_addr[k] = {tb[k], va[47-9*k -: 9], 3'b000};
    end
    if (inj < 0) begin
      w = 1'($urandom % 2); u = 1'($urandom % 2); f = 1'(($urandom % 4) == 0);
    end else begin
      w = (kind == 1) || (kind == 4) || (kind == 5);
      u = (kind == 2) || (kind == 4);
      f = (kind == 3);
    end
    mem.delete();
    for (int k = 0; k < 4; k++) mem[ent_addr[k]] = ent[k];
    rd_log.delete();
    wr_cnt = 0;
    model();
    case (exp_cause)
      2'b01:   tag = "R2";
      2'b10:   tag = "R3";
      2'b11:   tag = "R4";
      default: tag = "R8";
    endcase

    @(negedge clk);
    req_valid = 1'b1; req_vaddr = va; req_write = w; req_user = u; req_fetch = f;
    root_ppn = tb[0];
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 busy after accept", 64'(req_ready), 64'h0);
    n = 0; bad = 1'b0;
    while (!rsp_valid && n < 1000) begin
      if (req_ready) bad = 1'b1;
      @(negedge clk);
      n++;
    end
    chk("R10 ready low during walk", 64'(bad), 64'h0);
    chk("R10 walk completes", 64'(rsp_valid), 64'h1);
    chk({tag, " fault flag"}, 64'(rsp_fault), 64'(exp_cause != 2'b00));
    chk({tag, " cause"}, 64'(rsp_cause), 64'(exp_cause));
    chk({tag, " paddr"}, 64'(rsp_paddr), 64'(exp_pa));
    pa0 = rsp_paddr; c0 = rsp_cause;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk("R9 response held", {11'h0, rsp_valid, rsp_cause, pa0 ^ rsp_paddr}, {11'h0, 1'b1, c0, 52'h0});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk("R10 ready after handshake", 64'({req_ready, rsp_valid}), 64'h2);

    chk("R1 read count", 64'(rd_log.size()), 64'(exp_nrd));
    for (int k = 0; k < exp_nrd && k < rd_log.size(); k++)
      chk("R1 read address", 64'(rd_log[k]), 64'(exp_rd[k]));
    chk("R7 write count", 64'(wr_cnt), 64'(exp_nwr));
    for (int k = 0; k < 4; k++)
      chk(k == 3 ? "R6 level-4 entry after walk" : "R5 entry after walk",
          mem[ent_addr[k]], exp_ent[k]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk("R10 reset state", 64'({req_ready, rsp_valid, mem_req_valid}), 64'h4);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 idle after reset", 64'({req_ready, rsp_valid, mem_req_valid}), 64'h4);

    // each fault kind at each level, including the cause priority case
    for (int kind = 0; kind < 5; kind++)
      for (int lvl = 0; lvl < 4; lvl++)
        run(lvl, kind, kind % 3);
    // flags already set on a store; flags clear on a load
    for (int i = 0; i < 6; i++) begin
      run(0, 5, i % 2);
      run(0, 6, i % 3);
    end
    for (int i = 0; i < 400; i++) run(-1, 0, int'($urandom % 3));

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule